// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block sits between a two-channel sample source and the parallel output pins. Each cycle it takes an 8-bit sample and an over-range flag for channel A and for channel B. It turns them into the words that drive the pads. Static configuration inputs choose what each output carries:

- the live samples;
- a free-running ramp that replaces live data;
- the truncated mean of both channels, placed on both outputs.

Configuration also selects offset-binary or two's-complement coding and whether the bit order is mirrored.

While the outputs are powered down, a 2-bit mode input sets what the pins do. They either float, with the enable dropped, or are actively driven low. Every output is registered, so a result appears one clock after the inputs that produced it. Pad drive, termination and output-timing adjustment are outside this block. The output enable is a plain logic signal for the pad ring.

Top module: `dual_adc_fmt`

## Requirements
- R1: With all modes off, each channel's output word equals that channel's input sample from the previous clock edge (one-cycle latency), with the output enable high.
- R2: Outside test mode, each channel's over-range output follows its own input flag with one cycle of latency. In averaging mode, both flags are the OR of the two input flags.
- R3: When two's-complement coding is selected, output bit 7 (the MSB) is the inverse of the offset-binary MSB, and bits 6..0 are unchanged.
- R4: When mirroring is selected, input bit i appears on output bit 7-i. The mirror is applied after the coding step.
- R5: In averaging mode, both outputs carry (A + B) >> 1, computed on 9 bits from the offset-binary inputs with the remainder dropped.
- R6: After reset, all data and flag outputs are 0 and both output enables are 0.
- R7: In test mode, both outputs carry a ramp that starts at 0 on the first output after test mode is entered. The ramp rises by 1 each clock, wraps from 255 to 0, and overrides averaging and the live inputs.
- R8: In test mode, the coding and mirror steps are still applied to the ramp, and both over-range outputs are 0.
- R9: When power-down is asserted, data and flag outputs are 0. Mode 01 drives them low with the output enable at 1. Mode 00 (the default) and the unused codes 10 and 11 set the output enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_data | input | 8 | Channel A sample, offset binary |
| a_ovr | input | 1 | Channel A over-range flag |
| b_data | input | 8 | Channel B sample, offset binary |
| b_ovr | input | 1 | Channel B over-range flag |
| cfg_test | input | 1 | Replace samples with the ramp |
| cfg_avg | input | 1 | Put the mean of A and B on both outputs |
| cfg_twos | input | 1 | Two's-complement coding |
| cfg_rev | input | 1 | Mirror the bit order |
| cfg_pd | input | 1 | Outputs powered down |
| cfg_pd_mode | input | 2 | Powered-down state: 00 float, 01 drive low |
| a_out | output | 8 | Channel A output word |
| a_out_ovr | output | 1 | Channel A output over-range flag |
| a_out_oe | output | 1 | Channel A output enable |
| b_out | output | 8 | Channel B output word |
| b_out_ovr | output | 1 | Channel B output over-range flag |
| b_out_oe | output | 1 | Channel B output enable |

## Verification
On every cycle, the assertions check the following:

- the one-cycle pass-through;
- equal outputs in averaging mode;
- zeroed flags in test mode;
- the two powered-down pin states;
- the +1 step of the ramp whenever the ramp is shown uncoded.

Only the bench's scenarios can show the following:

- the exact values of coding and mirroring;
- the truncation of the mean;
- the wrap from 255 to 0;
- the restart of the ramp at 0 when test mode is re-entered, which depends on the history of the mode input.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
   typedef enum logic [1:0] {
      PD_FLOAT = 2'b00,
      PD_LOW   = 2'b01,
      PD_RSV2  = 2'b10,
      PD_RSV3  = 2'b11
   } pd_mode_e;
   localparam int NUM_CH = 2;
endpackage

// File: rtl/adcfmt_ramp.sv
module adcfmt_ramp #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic [DW-1:0] value
);
   localparam logic [DW-1:0] STEP = {{(DW-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         value <= '0;
      else
         value <= value + STEP;
   end
endmodule

// File: rtl/adcfmt_avg.sv
module adcfmt_avg #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] mean
);
   localparam int SW = DW + 1;
   logic [SW-1:0] sum;

   assign sum  = {1'b0, a} + {1'b0, b};
   assign mean = sum[SW-1:1];
endmodule

// File: rtl/adcfmt_lane.sv
module adcfmt_lane #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] din,
   input  logic          twos,
   input  logic          rev,
   output logic [DW-1:0] dout
);
   logic [DW-1:0] coded;
   logic [DW-1:0] mirrored;

   assign coded = {din[DW-1] ^ twos, din[DW-2:0]};

   for (genvar i = 0; i < DW; i++) begin : g_mirror
      assign mirrored[i] = coded[DW-1-i];
   end

   assign dout = rev ? mirrored : coded;
endmodule

// File: rtl/dual_adc_fmt.sv
module dual_adc_fmt
   import adcfmt_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] a_data,
   input  logic          a_ovr,
   input  logic [DW-1:0] b_data,
   input  logic          b_ovr,
   input  logic          cfg_test,
   input  logic          cfg_avg,
   input  logic          cfg_twos,
   input  logic          cfg_rev,
   input  logic          cfg_pd,
   input  logic [1:0]    cfg_pd_mode,
   output logic [DW-1:0] a_out,
   output logic          a_out_ovr,
   output logic          a_out_oe,
   output logic [DW-1:0] b_out,
   output logic          b_out_ovr,
   output logic          b_out_oe
);
   if (DW < 2) begin : g_bad_width
      $error("dual_adc_fmt: DW must be at least 2");
   end

   logic [DW-1:0] ramp_val;
   logic [DW-1:0] mean_val;
   logic [DW-1:0] live  [NUM_CH];
   logic          lovr  [NUM_CH];
   logic [DW-1:0] d_q   [NUM_CH];
   logic          ovr_q [NUM_CH];
   logic          oe_q  [NUM_CH];
   logic          hold_low;

   assign live[0] = a_data;
   assign live[1] = b_data;
   assign lovr[0] = a_ovr;
   assign lovr[1] = b_ovr;
   assign hold_low = (pd_mode_e'(cfg_pd_mode) == PD_LOW);

   adcfmt_ramp #(.DW(DW)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (cfg_test),
      .value (ramp_val)
   );

   adcfmt_avg #(.DW(DW)) u_avg (
      .a    (a_data),
      .b    (b_data),
      .mean (mean_val)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [DW-1:0] src;
      logic          src_ovr;
      logic [DW-1:0] fmt;

      always_comb begin
         if (cfg_test) begin
            src     = ramp_val;
            src_ovr = 1'b0;
         end else if (cfg_avg) begin
            src     = mean_val;
            src_ovr = a_ovr | b_ovr;
         end else begin
            src     = live[ch];
            src_ovr = lovr[ch];
         end
      end

      adcfmt_lane #(.DW(DW)) u_lane (
         .din  (src),
         .twos (cfg_twos),
         .rev  (cfg_rev),
         .dout (fmt)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            d_q[ch]   <= '0;
            ovr_q[ch] <= 1'b0;
            oe_q[ch]  <= 1'b0;
         end else if (cfg_pd) begin
            d_q[ch]   <= '0;
            ovr_q[ch] <= 1'b0;
            oe_q[ch]  <= hold_low;
         end else begin
            d_q[ch]   <= fmt;
            ovr_q[ch] <= src_ovr;
            oe_q[ch]  <= 1'b1;
         end
      end
   end

   assign a_out     = d_q[0];
   assign a_out_ovr = ovr_q[0];
   assign a_out_oe  = oe_q[0];
   assign b_out     = d_q[1];
   assign b_out_ovr = ovr_q[1];
   assign b_out_oe  = oe_q[1];
endmodule

// File: rtl/adcfmt_chk.sv
module adcfmt_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] a_data,
   input logic          a_ovr,
   input logic [DW-1:0] b_data,
   input logic          b_ovr,
   input logic          cfg_test,
   input logic          cfg_avg,
   input logic          cfg_twos,
   input logic          cfg_rev,
   input logic          cfg_pd,
   input logic [1:0]    cfg_pd_mode,
   input logic [DW-1:0] a_out,
   input logic          a_out_ovr,
   input logic          a_out_oe,
   input logic [DW-1:0] b_out,
   input logic          b_out_ovr,
   input logic          b_out_oe
);
   // R1
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_test && !cfg_avg && !cfg_twos && !cfg_rev && !cfg_pd)
      |=> (a_out == $past(a_data) && b_out == $past(b_data) && a_out_oe && b_out_oe));

   // R5
   avg_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_avg && !cfg_test && !cfg_pd) |=> (a_out == b_out && a_out_ovr == b_out_ovr));

   // R8
   test_ovr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_test |=> (!a_out_ovr && !b_out_ovr));

   // R7
   ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_test && $past(cfg_test) && !cfg_twos && !cfg_rev && !cfg_pd
       && !$past(cfg_twos) && !$past(cfg_rev) && !$past(cfg_pd))
      |=> (a_out == DW'($past(a_out) + 1'b1)));

   // R9
   pd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pd && cfg_pd_mode != 2'b01) |=> (!a_out_oe && !b_out_oe && a_out == '0 && b_out == '0));

   // R9
   pd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pd && cfg_pd_mode == 2'b01)
      |=> (a_out_oe && b_out_oe && a_out == '0 && b_out == '0 && !a_out_ovr && !b_out_ovr));
endmodule

bind dual_adc_fmt adcfmt_chk #(.DW(DW)) u_chk (.*);

// File: tb/dual_adc_fmt_tb.sv
module dual_adc_fmt_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   typedef struct packed {
      logic [7:0] a;
      logic [7:0] b;
      logic       ao, bo, avg, tw, rev, pd;
      logic [1:0] pm;
      logic [7:0] ea;
      logic [7:0] eb;
      logic       eao, ebo, eoe;
   } vec_t;

   localparam int NV = 11;
   // a, b, ao, bo, avg, tw, rev, pd, pm, ea, eb, eao, ebo, eoe
   localparam vec_t VEC [NV] = '{
      '{8'h12, 8'h34, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'h12, 8'h34, 1'b0, 1'b0, 1'b1}, // R1
      '{8'h80, 8'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'h80, 8'h7F, 1'b1, 1'b0, 1'b1}, // R2
      '{8'h80, 8'h7F, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b1}, // R3
      '{8'h01, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'h80, 8'h03, 1'b0, 1'b0, 1'b1}, // R4
      '{8'h01, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 8'h81, 8'h41, 1'b0, 1'b0, 1'b1}, // R4
      '{8'hFF, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 8'h80, 8'h80, 1'b1, 1'b1, 1'b1}, // R5
      '{8'h03, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 8'h03, 8'h03, 1'b0, 1'b0, 1'b1}, // R5
      '{8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 8'h7F, 8'h7F, 1'b0, 1'b0, 1'b1}, // R5
      '{8'hAA, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0}, // R9
      '{8'hAA, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1}, // R9
      '{8'hAA, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0}  // R9
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] a_data, b_data;
   logic       a_ovr, b_ovr;
   logic       cfg_test, cfg_avg, cfg_twos, cfg_rev, cfg_pd;
   logic [1:0] cfg_pd_mode;
   logic [7:0] a_out, b_out;
   logic       a_out_ovr, a_out_oe, b_out_ovr, b_out_oe;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_adc_fmt u_dut (
      .clk(clk), .rst_n(rst_n),
      .a_data(a_data), .a_ovr(a_ovr), .b_data(b_data), .b_ovr(b_ovr),
      .cfg_test(cfg_test), .cfg_avg(cfg_avg), .cfg_twos(cfg_twos),
      .cfg_rev(cfg_rev), .cfg_pd(cfg_pd), .cfg_pd_mode(cfg_pd_mode),
      .a_out(a_out), .a_out_ovr(a_out_ovr), .a_out_oe(a_out_oe),
      .b_out(b_out), .b_out_ovr(b_out_ovr), .b_out_oe(b_out_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic set_cfg(input logic t, input logic av, input logic tw, input logic rv);
      @(negedge clk);
      cfg_test = t;
      cfg_avg  = av;
      cfg_twos = tw;
      cfg_rev  = rv;
      cfg_pd   = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0;
      a_data = 8'h5A; b_data = 8'hA5; a_ovr = 1'b1; b_ovr = 1'b1;
      cfg_test = 1'b0; cfg_avg = 1'b0; cfg_twos = 1'b0; cfg_rev = 1'b0;
      cfg_pd = 1'b0; cfg_pd_mode = 2'b00;
      tick; tick;
      check("R6 a_out", {24'd0, a_out}, 32'd0);
      check("R6 b_out", {24'd0, b_out}, 32'd0);
      check("R6 flags/oe", {28'd0, a_out_ovr, b_out_ovr, a_out_oe, b_out_oe}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         a_data = VEC[i].a; b_data = VEC[i].b; a_ovr = VEC[i].ao; b_ovr = VEC[i].bo;
         cfg_avg = VEC[i].avg; cfg_twos = VEC[i].tw; cfg_rev = VEC[i].rev;
         cfg_pd = VEC[i].pd; cfg_pd_mode = VEC[i].pm;
         tick;
         check($sformatf("vec%0d R1-R5/R9 a_out", i), {24'd0, a_out}, {24'd0, VEC[i].ea});
         check($sformatf("vec%0d b_out", i), {24'd0, b_out}, {24'd0, VEC[i].eb});
         check($sformatf("vec%0d ovr (R2)", i), {30'd0, a_out_ovr, b_out_ovr},
               {30'd0, VEC[i].eao, VEC[i].ebo});
         check($sformatf("vec%0d oe (R9)", i), {30'd0, a_out_oe, b_out_oe},
               {30'd0, VEC[i].eoe, VEC[i].eoe});
      end

      // R7: ramp overrides averaging and live data, wraps after 255
      a_ovr = 1'b1; b_ovr = 1'b1;
      set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 300; i++) begin
         tick;
         check("R7 ramp a", {24'd0, a_out}, i % 256);
         check("R7 ramp b", {24'd0, b_out}, i % 256);
         check("R8 ramp ovr", {30'd0, a_out_ovr, b_out_ovr}, 32'd0);
      end

      // R7 restart at 0 on re-entry, R8 coding still applied
      set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
      tick;
      set_cfg(1'b1, 1'b0, 1'b1, 1'b0);
      tick;
      check("R8 restart coded", {24'd0, a_out}, 32'h80);
      tick;
      check("R8 coded next", {24'd0, b_out}, 32'h81);
      set_cfg(1'b1, 1'b0, 1'b0, 1'b1);
      tick;
      check("R8 ramp mirrored", {24'd0, a_out}, 32'h40);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule